// File: doc/BRIEF.md
# Two-Level Event Dispatch Unit

This unit decides where an event lands when interrupts, traps and exceptions are delivered under a simplified two-level privilege model. For each event it takes a vector number and the privilege ring the event arrived from. It combines these with a single mode-enable bit and a configured base address. From them it produces the handler entry address, the ring the handler runs in, and a flag telling the stack logic whether to switch stacks. It also raises the request strobe for the saved frame, together with the byte counts of that frame and of the event-information record. It does not write either one to memory.

Handler slots sit at a fixed stride above the base. Each slot holds two entry points 64 bytes apart: one for events from user code and one for events from supervisor code. Rings 1 and 2 count as user. While the mode is enabled, a far call or far jump through a call gate is refused with a general-protection fault. When the mode is disabled, the unit computes no address and instead raises a request for the legacy delivery path. The unit also answers the two event-return requests, one to user and one to supervisor, each in a single cycle.

Top module: `evt_dispatch_unit`

## Requirements
- R1: With the mode enabled, an event yields on the next cycle `dispatch_valid`=1 and `entry_addr` = (`base_addr` + vector*128 + (64 if the origin ring is 0, else 0)) modulo 2^ADDR_W.
- R2: Every delivered event reports `new_ring` = 0.
- R3: An event from ring 1, 2 or 3 uses the lower entry and sets `stack_switch`=1. An event from ring 0 uses the upper entry and sets `stack_switch`=0.
- R4: With the mode disabled, an event yields on the next cycle `legacy_req`=1 with `dispatch_valid`=0, `entry_addr`=0 and `stack_switch`=0.
- R5: `gp_fault` is 1 on the cycle after a far transfer that references a call gate while the mode is enabled, and 0 after any other far-transfer combination.
- R6: A delivered event reports `frame_bytes`=40 and `info_bytes`=64. Both counts are 0 on every cycle without a delivery.
- R7: With the mode enabled, a user return yields on the next cycle `ret_valid`=1, `ret_ring`=3 and `ret_stack_switch`=1.
- R8: With the mode enabled, a supervisor return yields on the next cycle `ret_valid`=1, `ret_ring`=0 and `ret_stack_switch`=0.
- R9: An event in the same cycle as a return request wins, and that return produces no `ret_valid`. A user return wins over a supervisor return in the same cycle. With the mode disabled, return requests produce no `ret_valid`.
- R10: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Enables two-level dispatch |
| base_addr | input | ADDR_W | Base of the handler slot area |
| evt_valid | input | 1 | An event is being delivered |
| evt_vector | input | VEC_W | Event vector number |
| evt_ring | input | 2 | Ring the event arrived from |
| far_valid | input | 1 | A far call or far jump executes |
| far_gate | input | 1 | The far transfer references a call gate |
| ret_user_req | input | 1 | Return-to-user request |
| ret_sup_req | input | 1 | Return-to-supervisor request |
| dispatch_valid | output | 1 | Entry address is valid |
| entry_addr | output | ADDR_W | Handler entry address |
| new_ring | output | 2 | Ring of the handler |
| stack_switch | output | 1 | Switch to the supervisor stack |
| frame_bytes | output | CNT_W | Bytes of the saved stack frame |
| info_bytes | output | CNT_W | Bytes of event information |
| legacy_req | output | 1 | Hand the event to the legacy path |
| gp_fault | output | 1 | General-protection fault on a gated far transfer |
| ret_valid | output | 1 | A return has been accepted |
| ret_ring | output | 2 | Ring after the return |
| ret_stack_switch | output | 1 | Return switches stacks |

## Verification
The bench builds the unit with ADDR_W=16 and VEC_W=4. This keeps the sweep exhaustive: every one of the 16 vectors is tried from every one of the 4 origin rings, with the mode on and off, against three base addresses. One of those bases sits close enough to the top of the 16-bit space that the sum wraps, which puts the modulo behaviour of the address adder within reach. The far-transfer and return inputs are also swept over all their combinations, including collisions with a simultaneous event.

// File: rtl/evt_dispatch_pkg.sv
// Package: shared ring encodings and byte-count constants for the event
// dispatch unit. Assumes rings are encoded 0 (most privileged) to 3.
package evt_dispatch_pkg;
    typedef logic [1:0] ring_t;

    localparam ring_t RING_SUP  = 2'd0;
    localparam ring_t RING_USER = 2'd3;

    localparam int SLOT_SHIFT  = 7;   // 128-byte slot per vector
    localparam int TWIN_GAP    = 64;  // distance between the two entries
    localparam int FRAME_BYTES = 40;
    localparam int INFO_BYTES  = 64;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_USER = 2'd1,
        RET_SUP  = 2'd2
    } ret_kind_t;
endpackage

// File: rtl/evt_priv_fold.sv
// Module: folds the four-ring origin into the two-level model.
// Assumes ring 0 is supervisor and every other ring counts as user.
module evt_priv_fold
    import evt_dispatch_pkg::*;
(
    input  ring_t origin_ring,
    output logic  from_user
);
    // Fold rings 1..3 into user level.
    always_comb begin
        from_user = (origin_ring != RING_SUP);
    end
endmodule

// File: rtl/evt_entry_calc.sv
// Module: computes a handler entry address as base + vector slot + twin
// offset. Purely combinational; the sum wraps modulo 2^ADDR_W.
// Assumes VEC_W + SLOT_SHIFT fits in ADDR_W.
module evt_entry_calc
    import evt_dispatch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vector,
    input  logic              from_user,
    output logic [ADDR_W-1:0] entry
);
    localparam logic [ADDR_W-1:0] GAP = ADDR_W'(TWIN_GAP);

    logic [ADDR_W-1:0] slot_off;
    logic [ADDR_W-1:0] twin_off;

    // Slot offset: vector scaled by the slot size.
    always_comb begin
        slot_off = ADDR_W'(vector) << SLOT_SHIFT;
    end

    // Twin offset: the upper entry serves events from supervisor code.
    always_comb begin
        twin_off = from_user ? '0 : GAP;
    end

    // Final entry address.
    always_comb begin
        entry = base + slot_off + twin_off;
    end
endmodule

// File: rtl/evt_gate_check.sv
// Module: refuses far transfers through call gates while the two-level
// mode is enabled. Combinational; registered by the parent.
module evt_gate_check (
    input  logic mode_en,
    input  logic far_valid,
    input  logic far_gate,
    output logic fault
);
    // A gated far transfer under the enabled mode is a protection fault.
    always_comb begin
        fault = mode_en && far_valid && far_gate;
    end
endmodule

// File: rtl/evt_dispatch_unit.sv
// Module: top of the two-level event dispatch unit. Registers the entry
// address, privilege results, fault flag and return answers one cycle
// after the request. An event outranks returns; a user return outranks a
// supervisor return. Synchronous active-low reset clears every output.
module evt_dispatch_unit
    import evt_dispatch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              evt_valid,
    input  logic [VEC_W-1:0]  evt_vector,
    input  logic [1:0]        evt_ring,
    input  logic              far_valid,
    input  logic              far_gate,
    input  logic              ret_user_req,
    input  logic              ret_sup_req,
    output logic              dispatch_valid,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [1:0]        new_ring,
    output logic              stack_switch,
    output logic [CNT_W-1:0]  frame_bytes,
    output logic [CNT_W-1:0]  info_bytes,
    output logic              legacy_req,
    output logic              gp_fault,
    output logic              ret_valid,
    output logic [1:0]        ret_ring,
    output logic              ret_stack_switch
);
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BYTES);
    localparam logic [CNT_W-1:0] INFO_CNT  = CNT_W'(INFO_BYTES);

    logic              from_user;
    logic [ADDR_W-1:0] entry_nxt;
    logic              fault_nxt;
    logic              deliver;
    logic              to_legacy;
    ret_kind_t         ret_sel;

    evt_priv_fold u_fold (
        .origin_ring (evt_ring),
        .from_user   (from_user)
    );

    evt_entry_calc #(
        .ADDR_W (ADDR_W),
        .VEC_W  (VEC_W)
    ) u_calc (
        .base      (base_addr),
        .vector    (evt_vector),
        .from_user (from_user),
        .entry     (entry_nxt)
    );

    evt_gate_check u_gate (
        .mode_en   (mode_en),
        .far_valid (far_valid),
        .far_gate  (far_gate),
        .fault     (fault_nxt)
    );

    // Split events between the two-level path and the legacy path.
    always_comb begin
        deliver   = evt_valid && mode_en;
        to_legacy = evt_valid && !mode_en;
    end

    // Choose the return to serve: events first, then user, then supervisor.
    always_comb begin
        ret_sel = RET_NONE;
        if (mode_en && !evt_valid) begin
            if (ret_user_req)     ret_sel = RET_USER;
            else if (ret_sup_req) ret_sel = RET_SUP;
        end
    end

    // Delivery result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dispatch_valid <= 1'b0;
            entry_addr     <= '0;
            new_ring       <= '0;
            stack_switch   <= 1'b0;
            frame_bytes    <= '0;
            info_bytes     <= '0;
            legacy_req     <= 1'b0;
        end else begin
            dispatch_valid <= deliver;
            entry_addr     <= deliver ? entry_nxt : '0;
            new_ring       <= RING_SUP;
            stack_switch   <= deliver && from_user;
            frame_bytes    <= deliver ? FRAME_CNT : '0;
            info_bytes     <= deliver ? INFO_CNT : '0;
            legacy_req     <= to_legacy;
        end
    end

    // Protection fault register.
    always_ff @(posedge clk) begin
        if (!rst_n) gp_fault <= 1'b0;
        else        gp_fault <= fault_nxt;
    end

    // Return result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid        <= 1'b0;
            ret_ring         <= '0;
            ret_stack_switch <= 1'b0;
        end else begin
            ret_valid        <= (ret_sel != RET_NONE);
            ret_ring         <= (ret_sel == RET_USER) ? RING_USER : RING_SUP;
            ret_stack_switch <= (ret_sel == RET_USER);
        end
    end

    // R2: a handler always runs in ring 0.
    a_r2_handler_ring0: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> new_ring == RING_SUP);

    // R1: a delivery only follows an enabled-mode event.
    a_r1_delivery_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> $past(evt_valid && mode_en));

    // R3: the stack switch follows the folded origin ring.
    a_r3_switch_origin: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> stack_switch == ($past(evt_ring) != RING_SUP));

    // R4: legacy hand-off and delivery never coincide.
    a_r4_legacy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_req |-> !dispatch_valid && entry_addr == '0);

    // R5: a fault is always caused by a gated far transfer in the enabled mode.
    a_r5_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> $past(mode_en && far_valid && far_gate));

    // R6: byte counts appear only alongside a delivery.
    a_r6_counts_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dispatch_valid |-> frame_bytes == '0 && info_bytes == '0);

    // R9: an accepted return never shares a cycle with a delivery or legacy hand-off.
    a_r9_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dispatch_valid, legacy_req, ret_valid}));

    // R7: a user return lands in ring 3 on the user stack.
    a_r7_user_return: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && ret_stack_switch |-> ret_ring == RING_USER);
endmodule

// File: tb/evt_dispatch_unit_tb.sv
module evt_dispatch_unit_tb;
    localparam int AW = 16;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_en;
    logic [AW-1:0] base_addr;
    logic          evt_valid;
    logic [VW-1:0] evt_vector;
    logic [1:0]    evt_ring;
    logic          far_valid, far_gate, ret_user_req, ret_sup_req;
    logic          dispatch_valid;
    logic [AW-1:0] entry_addr;
    logic [1:0]    new_ring;
    logic          stack_switch;
    logic [7:0]    frame_bytes, info_bytes;
    logic          legacy_req, gp_fault, ret_valid;
    logic [1:0]    ret_ring;
    logic          ret_stack_switch;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    evt_dispatch_unit #(.ADDR_W(AW), .VEC_W(VW), .CNT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .base_addr(base_addr),
        .evt_valid(evt_valid), .evt_vector(evt_vector), .evt_ring(evt_ring),
        .far_valid(far_valid), .far_gate(far_gate),
        .ret_user_req(ret_user_req), .ret_sup_req(ret_sup_req),
        .dispatch_valid(dispatch_valid), .entry_addr(entry_addr),
        .new_ring(new_ring), .stack_switch(stack_switch),
        .frame_bytes(frame_bytes), .info_bytes(info_bytes),
        .legacy_req(legacy_req), .gp_fault(gp_fault), .ret_valid(ret_valid),
        .ret_ring(ret_ring), .ret_stack_switch(ret_stack_switch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_valid = 0; far_valid = 0; far_gate = 0;
        ret_user_req = 0; ret_sup_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int bases [3] = '{0, 'h1234, 'hFF80};
        rst_n = 0; mode_en = 0; base_addr = 0; evt_vector = 0; evt_ring = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 dispatch_valid", 32'(dispatch_valid), 0);
        check("R10 entry_addr", 32'(entry_addr), 0);
        check("R10 legacy_req", 32'(legacy_req), 0);
        check("R10 gp_fault", 32'(gp_fault), 0);
        check("R10 ret_valid", 32'(ret_valid), 0);
        check("R10 frame_bytes", 32'(frame_bytes), 0);
        rst_n = 1;
        @(negedge clk);
        check("R10 after release", 32'({dispatch_valid, legacy_req, ret_valid, gp_fault}), 0);
        check("R6 idle counts", 32'({frame_bytes, info_bytes}), 0);

        // R1..R6 exhaustive event sweep
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 3; b++) begin
                for (int v = 0; v < 16; v++) begin
                    for (int r = 0; r < 4; r++) begin
                        int exp_addr;
                        mode_en = 1'(m); base_addr = AW'(bases[b]);
                        evt_valid = 1; evt_vector = VW'(v); evt_ring = 2'(r);
                        @(negedge clk);
                        evt_valid = 0;
                        if (m == 1) begin
                            exp_addr = (bases[b] + v * 128 + ((r == 0) ? 64 : 0)) % 65536;
                            check("R1 dispatch_valid", 32'(dispatch_valid), 1);
                            check("R1 entry_addr", 32'(entry_addr), 32'(exp_addr));
                            check("R2 new_ring", 32'(new_ring), 0);
                            check("R3 stack_switch", 32'(stack_switch), (r != 0) ? 1 : 0);
                            check("R6 frame_bytes", 32'(frame_bytes), 40);
                            check("R6 info_bytes", 32'(info_bytes), 64);
                            check("R4 no legacy", 32'(legacy_req), 0);
                        end else begin
                            check("R4 legacy_req", 32'(legacy_req), 1);
                            check("R4 dispatch_valid", 32'(dispatch_valid), 0);
                            check("R4 entry_addr", 32'(entry_addr), 0);
                            check("R4 stack_switch", 32'(stack_switch), 0);
                            check("R6 counts legacy", 32'({frame_bytes, info_bytes}), 0);
                        end
                        @(negedge clk);
                        check("R6 counts idle", 32'({frame_bytes, info_bytes}), 0);
                    end
                end
            end
        end

        // R5 far-transfer sweep
        for (int m = 0; m < 2; m++) begin
            for (int fv = 0; fv < 2; fv++) begin
                for (int fg = 0; fg < 2; fg++) begin
                    mode_en = 1'(m); far_valid = 1'(fv); far_gate = 1'(fg);
                    @(negedge clk);
                    idle_inputs();
                    check("R5 gp_fault", 32'(gp_fault), (m == 1 && fv == 1 && fg == 1) ? 1 : 0);
                    @(negedge clk);
                    check("R5 gp_fault cleared", 32'(gp_fault), 0);
                end
            end
        end

        // R7 R8 R9 return sweep
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 2; e++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int s = 0; s < 2; s++) begin
                        mode_en = 1'(m); base_addr = 0; evt_vector = 0; evt_ring = 3;
                        evt_valid = 1'(e); ret_user_req = 1'(u); ret_sup_req = 1'(s);
                        @(negedge clk);
                        idle_inputs();
                        if (m == 1 && e == 0 && u == 1) begin
                            check("R7 ret_valid", 32'(ret_valid), 1);
                            check("R7 ret_ring", 32'(ret_ring), 3);
                            check("R7 ret_stack_switch", 32'(ret_stack_switch), 1);
                        end else if (m == 1 && e == 0 && s == 1) begin
                            check("R8 ret_valid", 32'(ret_valid), 1);
                            check("R8 ret_ring", 32'(ret_ring), 0);
                            check("R8 ret_stack_switch", 32'(ret_stack_switch), 0);
                        end else begin
                            check("R9 no ret_valid", 32'(ret_valid), 0);
                            if (e == 1)
                                check("R9 event wins", 32'({dispatch_valid, legacy_req}), (m == 1) ? 2 : 1);
                        end
                        @(negedge clk);
                        check("R9 ret_valid drops", 32'(ret_valid), 0);
                    end
                end
            end
        end

        finish_run();
    end
endmodule